// File: doc/BRIEF.md
# PCI Target Transaction Phase Tracker

This block is the front end of a simple 32-bit PCI target. It watches the bus control inputs: frame, initiator ready and idsel. It also watches the multiplexed address/data and command/byte-enable inputs. When a transaction starts, it records the address and the command. It claims a memory access when the address falls inside a power-of-two window placed at a base address. It claims a configuration access when idsel is high on the address edge. After a claim it drives device select and target ready. Each completed data phase is handed to the local side as one beat on a valid/ready stream.

Each bus line that a real target would tri-state is split into separate pins. Data toward the bus leaves on `ad_o`, which is qualified by `ad_oe_o`. Device select and target ready are qualified by `ctl_oe_o`. The initiator moves a burst one beat at a time, and the block adds four to the recorded address for every completed beat.

The local stream follows one rule, because a beat completes on the bus edge itself. `xfer_ready_i` sampled high on an edge allows the target to assert target ready in the next cycle. Any beat presented with `xfer_valid_o` high is taken on that edge and cannot be refused. If the local side pulls ready low, target-ready wait states appear on the bus one cycle later.

Top module: `pci_tgt_tracker`

## Requirements
- R1: While `rst_n` is low, even when it falls between clock edges, `devsel_n_o` and `trdy_n_o` are high, `ctl_oe_o`, `ad_oe_o` and `xfer_valid_o` are low, and the block is idle.
- R2: The first rising edge on which `frame_n_i` is sampled low while idle is the address phase. On that edge `ad_i` is stored as the start address and `cbe_n_i` is taken as the command. A memory command whose `ad_i[31:WIN_BITS]` equals the same bits of `BASE_ADDR` is claimed, and `devsel_n_o` goes low after the next rising edge.
- R3: `trdy_n_o` goes low one edge after `devsel_n_o` goes low, when `xfer_ready_i` is high on that edge. This applies to reads and to writes.
- R4: A data phase completes only on an edge where `irdy_n_i` and `trdy_n_o` are both low. `xfer_valid_o` is high in exactly those cycles. In the same cycle `xfer_be_o` equals `~cbe_n_i`, and `xfer_data_o` equals `ad_i` for writes and `rd_data_i` for reads.
- R5: `xfer_addr_o` gives the start address on the first beat and rises by 4 after every completed beat.
- R6: `xfer_last_o` is high on a beat where `frame_n_i` is high. On the edge that completes that beat, `devsel_n_o` and `trdy_n_o` return high, and a new address phase is accepted on the very next edge.
- R7: Command 4'b1010 (configuration read) or 4'b1011 (configuration write) is claimed whenever `idsel_i` is high on the address edge, whatever the address is. With `idsel_i` low the same command is not claimed.
- R8: Commands other than 4'b0110 (memory read), 4'b0111 (memory write), 4'b1010 and 4'b1011 are ignored, and so is a memory address outside the window. For such a transaction `devsel_n_o` stays high and no beat is produced, until an edge where `frame_n_i` and `irdy_n_i` are both high.
- R9: During a claimed read, from the `devsel_n_o`-low cycle to the final beat, `ad_oe_o` is high and `ad_o` equals `rd_data_i`. During writes `ad_oe_o` is low.
- R10: `xfer_ready_i` sampled low while device select is asserted holds `trdy_n_o` high in the next cycle, so no beat completes in that cycle.
- R11: `ctl_oe_o` is high from the cycle after the address phase until one cycle after device select is released, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | Frame from the initiator, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| idsel_i | input | 1 | Configuration chip select |
| ad_i | input | 32 | Address/data bus as seen from the pins |
| cbe_n_i | input | 4 | Command or active-low byte enables |
| ad_o | output | 32 | Read data driven toward the bus |
| ad_oe_o | output | 1 | Enable for `ad_o` |
| devsel_n_o | output | 1 | Device select, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| ctl_oe_o | output | 1 | Enable for device select and target ready |
| xfer_valid_o | output | 1 | A data phase completes this cycle |
| xfer_ready_i | input | 1 | Local side allows target ready next cycle |
| xfer_addr_o | output | 32 | Byte address of the beat |
| xfer_data_o | output | 32 | Beat data |
| xfer_be_o | output | 4 | Byte enables, active high |
| xfer_write_o | output | 1 | Beat belongs to a write |
| xfer_cfg_o | output | 1 | Beat belongs to a configuration access |
| xfer_last_o | output | 1 | Final beat of the transaction |
| rd_data_i | input | 32 | Data the local side returns for reads |

## Verification
Several rules are checked by assertions on every cycle:
- target ready never precedes device select;
- a valid beat always comes with device select asserted;
- the final beat releases both control outputs;
- an intermediate beat moves the address by four;
- back-pressure holds target ready high;
- both output enables imply the control enable.

The bench scenarios cover what those cycle rules cannot show:
- the exact cycle on which device select first falls;
- which commands and address/idsel combinations are claimed;
- read data steering;
- the skip state for ignored transactions;
- a frame that starts the cycle after a release;
- a reset that lands in mid-transaction.

// File: rtl/pci_tt_pkg.sv
package pci_tt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEC  = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } tt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

endpackage

// File: rtl/pci_tt_decode.sv
module pci_tt_decode
  import pci_tt_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              WIN_BITS  = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:WIN_BITS] tag_i,
  input  logic [3:0]               cmd_i,
  input  logic                     idsel_i,
  output logic                     claim_o,
  output logic                     is_write_o,
  output logic                     is_cfg_o
);

  localparam logic [ADDR_W-1:WIN_BITS] BASE_TAG = BASE_ADDR[ADDR_W-1:WIN_BITS];

  logic mem_cmd;
  logic cfg_cmd;
  logic in_window;

  always_comb begin
    mem_cmd    = 1'b0;
    cfg_cmd    = 1'b0;
    is_write_o = 1'b0;
    unique case (cmd_i)
      CMD_MEM_RD: mem_cmd = 1'b1;
      CMD_MEM_WR: begin mem_cmd = 1'b1; is_write_o = 1'b1; end
      CMD_CFG_RD: cfg_cmd = 1'b1;
      CMD_CFG_WR: begin cfg_cmd = 1'b1; is_write_o = 1'b1; end
      default: ;
    endcase
  end

  assign in_window = (tag_i == BASE_TAG);
  assign is_cfg_o  = cfg_cmd;
  assign claim_o   = (mem_cmd && in_window) || (cfg_cmd && idsel_i);

endmodule

// File: rtl/pci_tt_fsm.sv
module pci_tt_fsm
  import pci_tt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_n_i,
  input  logic      irdy_n_i,
  input  logic      claim_i,
  input  logic      ready_i,
  output tt_state_e state_o,
  output logic      devsel_n_o,
  output logic      trdy_n_o,
  output logic      drive_hi_o,
  output logic      capture_o,
  output logic      beat_o,
  output logic      final_o
);

  tt_state_e state_q;
  logic      devsel_q;
  logic      trdy_q;
  logic      drive_hi_q;

  assign capture_o = (state_q == ST_IDLE) && !frame_n_i;
  assign beat_o    = (state_q == ST_DATA) && !trdy_q && !irdy_n_i;
  assign final_o   = beat_o && frame_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      devsel_q   <= 1'b1;
      trdy_q     <= 1'b1;
      drive_hi_q <= 1'b0;
    end else begin
      drive_hi_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (capture_o) state_q <= claim_i ? ST_DEC : ST_SKIP;
        end
        ST_DEC: begin
          state_q  <= ST_DATA;
          devsel_q <= 1'b0;
          trdy_q   <= 1'b1;
        end
        ST_DATA: begin
          if (final_o) begin
            state_q    <= ST_IDLE;
            devsel_q   <= 1'b1;
            trdy_q     <= 1'b1;
            drive_hi_q <= 1'b1;
          end else begin
            trdy_q <= !ready_i;
          end
        end
        ST_SKIP: begin
          if (frame_n_i && irdy_n_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign devsel_n_o = devsel_q;
  assign trdy_n_o   = trdy_q;
  assign drive_hi_o = drive_hi_q;

endmodule

// File: rtl/pci_tt_beat.sv
module pci_tt_beat #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              beat_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              is_write_i,
  input  logic              is_cfg_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic              cfg_o
);

  localparam int ADDR_STEP = DATA_W / 8;

  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic              cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      cfg_q   <= 1'b0;
    end else if (capture_i) begin
      addr_q  <= start_addr_i;
      write_q <= is_write_i;
      cfg_q   <= is_cfg_i;
    end else if (beat_i) begin
      addr_q  <= addr_q + ADDR_W'(ADDR_STEP);
    end
  end

  assign addr_o  = addr_q;
  assign write_o = write_q;
  assign cfg_o   = cfg_q;

endmodule

// File: rtl/pci_tgt_tracker.sv
module pci_tgt_tracker
  import pci_tt_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          WIN_BITS  = 12,
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  localparam int         BE_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n_i,
  input  logic              irdy_n_i,
  input  logic              idsel_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [BE_W-1:0]   cbe_n_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              devsel_n_o,
  output logic              trdy_n_o,
  output logic              ctl_oe_o,
  output logic              xfer_valid_o,
  input  logic              xfer_ready_i,
  output logic [DATA_W-1:0] xfer_addr_o,
  output logic [DATA_W-1:0] xfer_data_o,
  output logic [BE_W-1:0]   xfer_be_o,
  output logic              xfer_write_o,
  output logic              xfer_cfg_o,
  output logic              xfer_last_o,
  input  logic [DATA_W-1:0] rd_data_i
);

  tt_state_e state;
  logic      claim, dec_write, dec_cfg;
  logic      capture, beat, final_beat, drive_hi;
  logic      wr_q, cfg_q;

  pci_tt_decode #(
    .ADDR_W   (DATA_W),
    .WIN_BITS (WIN_BITS),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .tag_i     (ad_i[DATA_W-1:WIN_BITS]),
    .cmd_i     (cbe_n_i[3:0]),
    .idsel_i   (idsel_i),
    .claim_o   (claim),
    .is_write_o(dec_write),
    .is_cfg_o  (dec_cfg)
  );

  pci_tt_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n_i (frame_n_i),
    .irdy_n_i  (irdy_n_i),
    .claim_i   (claim),
    .ready_i   (xfer_ready_i),
    .state_o   (state),
    .devsel_n_o(devsel_n_o),
    .trdy_n_o  (trdy_n_o),
    .drive_hi_o(drive_hi),
    .capture_o (capture),
    .beat_o    (beat),
    .final_o   (final_beat)
  );

  pci_tt_beat #(
    .ADDR_W(DATA_W),
    .DATA_W(DATA_W)
  ) u_beat (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_i   (capture),
    .beat_i      (beat),
    .start_addr_i(ad_i),
    .is_write_i  (dec_write),
    .is_cfg_i    (dec_cfg),
    .addr_o      (xfer_addr_o),
    .write_o     (wr_q),
    .cfg_o       (cfg_q)
  );

  assign ctl_oe_o     = (state == ST_DEC) || (state == ST_DATA) || drive_hi;
  assign ad_oe_o      = (state == ST_DATA) && !wr_q;
  assign ad_o         = rd_data_i;
  assign xfer_valid_o = beat;
  assign xfer_last_o  = final_beat;
  assign xfer_data_o  = wr_q ? ad_i : rd_data_i;
  assign xfer_be_o    = ~cbe_n_i;
  assign xfer_write_o = wr_q;
  assign xfer_cfg_o   = cfg_q;

endmodule

// File: rtl/pci_tt_checker.sv
module pci_tt_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irdy_n_i,
  input logic              devsel_n_o,
  input logic              trdy_n_o,
  input logic              ctl_oe_o,
  input logic              ad_oe_o,
  input logic              xfer_valid_o,
  input logic              xfer_ready_i,
  input logic              xfer_last_o,
  input logic [DATA_W-1:0] xfer_addr_o
);

  assert_trdy_after_devsel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n_o) |-> !$past(devsel_n_o));

  assert_beat_needs_both_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> (!irdy_n_i && !devsel_n_o && !trdy_n_o));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_last_o) |=> (xfer_addr_o == $past(xfer_addr_o) + DATA_W'(4)));

  assert_release_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && xfer_last_o) |=> (devsel_n_o && trdy_n_o));

  assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ready_i && !devsel_n_o) |=> trdy_n_o);

  assert_read_oe_needs_ctl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> ctl_oe_o);

  assert_devsel_driven_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n_o || !trdy_n_o) |-> ctl_oe_o);

endmodule

bind pci_tgt_tracker pci_tt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irdy_n_i    (irdy_n_i),
  .devsel_n_o  (devsel_n_o),
  .trdy_n_o    (trdy_n_o),
  .ctl_oe_o    (ctl_oe_o),
  .ad_oe_o     (ad_oe_o),
  .xfer_valid_o(xfer_valid_o),
  .xfer_ready_i(xfer_ready_i),
  .xfer_last_o (xfer_last_o),
  .xfer_addr_o (xfer_addr_o)
);

// File: tb/pci_tgt_tracker_tb.sv
module pci_tgt_tracker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n_i = 1'b1, irdy_n_i = 1'b1, idsel_i = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_n_i = 4'hF;
  logic        xfer_ready_i = 1'b1;
  logic [31:0] rd_data_i = 32'hCAFE_0123;
  logic [31:0] ad_o, xfer_addr_o, xfer_data_o;
  logic [3:0]  xfer_be_o;
  logic        ad_oe_o, devsel_n_o, trdy_n_o, ctl_oe_o;
  logic        xfer_valid_o, xfer_write_o, xfer_cfg_o, xfer_last_o;

  localparam logic [31:0] RDV = 32'hCAFE_0123;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pci_tgt_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i),
    .idsel_i(idsel_i), .ad_i(ad_i), .cbe_n_i(cbe_n_i), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .devsel_n_o(devsel_n_o), .trdy_n_o(trdy_n_o),
    .ctl_oe_o(ctl_oe_o), .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
    .xfer_addr_o(xfer_addr_o), .xfer_data_o(xfer_data_o), .xfer_be_o(xfer_be_o),
    .xfer_write_o(xfer_write_o), .xfer_cfg_o(xfer_cfg_o), .xfer_last_o(xfer_last_o),
    .rd_data_i(rd_data_i)
  );

  typedef struct packed {
    logic        fr, ir, ids, rdy;
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic        dev, tr, v, l, coe, adoe;
    logic [31:0] addr;
  } vec_t;

  // fr ir ids rdy ad cbe | dev tr v last coe adoe addr
  localparam vec_t VECS [0:40] = '{
    // memory write burst of two: R2 R3 R4 R5 R6 R11
    '{1'b0,1'b1,1'b0,1'b1,32'h8000_0010,4'h7, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b0,1'b0,1'b0,1'b1,32'h1111_1111,4'h0, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b0,1'b0,1'b0,1'b1,32'h1111_1111,4'h0, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b0,1'b0,1'b0,1'b1,32'h1111_1111,4'h0, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,32'h8000_0010},
    '{1'b1,1'b0,1'b0,1'b1,32'h2222_2222,4'h3, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,32'h8000_0014},
    '{1'b1,1'b1,1'b0,1'b1,32'h0,4'hF,         1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b1,1'b1,1'b0,1'b1,32'h0,4'hF,         1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    // memory read with back-pressure and initiator wait: R9 R10
    '{1'b0,1'b1,1'b0,1'b1,32'h8000_0100,4'h6, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b0,1'b0,1'b0,1'b0,32'h0,4'h0,         1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b0,1'b0,1'b0,1'b0,32'h0,4'h0,         1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0},
    '{1'b0,1'b0,1'b0,1'b1,32'h0,4'h0,         1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0},
    '{1'b0,1'b0,1'b0,1'b0,32'h0,4'h0,         1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,32'h8000_0100},
    '{1'b0,1'b0,1'b0,1'b1,32'h0,4'h0,         1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0},
    '{1'b0,1'b1,1'b0,1'b1,32'h0,4'h0,         1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h0,4'h5,         1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,32'h8000_0104},
    '{1'b1,1'b1,1'b0,1'b1,32'h0,4'hF,         1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    // config write, idsel high, address outside window: R7
    '{1'b0,1'b1,1'b1,1'b1,32'h0000_0040,4'hB, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h3333_3333,4'h0, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h3333_3333,4'h0, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h3333_3333,4'h0, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,32'h0000_0040},
    '{1'b1,1'b1,1'b0,1'b1,32'h0,4'hF,         1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    // config read with idsel low, not claimed: R7 R8
    '{1'b0,1'b1,1'b0,1'b1,32'h0000_0040,4'hA, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h0,4'h0,         1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h0,4'h0,         1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b1,1'b1,1'b0,1'b1,32'h0,4'hF,         1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    // unsupported command inside window: R8
    '{1'b0,1'b1,1'b0,1'b1,32'h8000_0000,4'h3, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h0,4'h0,         1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b1,1'b1,1'b0,1'b1,32'h0,4'hF,         1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    // memory write outside window: R8
    '{1'b0,1'b1,1'b0,1'b1,32'h9000_0000,4'h7, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h0,4'h0,         1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b1,1'b1,1'b0,1'b1,32'h0,4'hF,         1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    // two single writes back to back: R6 R11
    '{1'b0,1'b1,1'b0,1'b1,32'h8000_0020,4'h7, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h4444_4444,4'h0, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h4444_4444,4'h0, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h4444_4444,4'h0, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,32'h8000_0020},
    '{1'b0,1'b1,1'b0,1'b1,32'h8000_0030,4'h7, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h5555_5555,4'h8, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h5555_5555,4'h8, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,32'h5555_5555,4'h8, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,32'h8000_0030},
    '{1'b1,1'b1,1'b0,1'b1,32'h0,4'hF,         1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0},
    '{1'b1,1'b1,1'b0,1'b1,32'h0,4'hF,         1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0}
  };

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic fr, input logic ir, input logic ids,
                       input logic [31:0] ad, input logic [3:0] cbe);
    frame_n_i = fr; irdy_n_i = ir; idsel_i = ids; ad_i = ad; cbe_n_i = cbe;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: state during reset
    check("R1 reset", {124'd0, devsel_n_o, trdy_n_o, ctl_oe_o | ad_oe_o, xfer_valid_o},
          {124'd0, 4'b1100});
    rst_n = 1'b1;

    for (int i = 0; i <= 40; i++) begin
      logic [127:0] got, exp;
      @(negedge clk);
      drive(VECS[i].fr, VECS[i].ir, VECS[i].ids, VECS[i].ad, VECS[i].cbe);
      xfer_ready_i = VECS[i].rdy;
      #1;
      got = {58'd0, devsel_n_o, trdy_n_o, xfer_valid_o, ctl_oe_o, ad_oe_o,
             (ad_oe_o ? ad_o : 32'h0), 1'b0, 32'h0, 32'h0};
      exp = {58'd0, VECS[i].dev, VECS[i].tr, VECS[i].v, VECS[i].coe, VECS[i].adoe,
             (VECS[i].adoe ? RDV : 32'h0), 1'b0, 32'h0, 32'h0};
      if (VECS[i].v) begin
        got[64:0] = {xfer_last_o, xfer_addr_o, xfer_data_o ^ {28'd0, xfer_be_o}};
        exp[64:0] = {VECS[i].l, VECS[i].addr,
                     (VECS[i].adoe ? RDV : VECS[i].ad) ^ {28'd0, ~VECS[i].cbe}};
      end
      check($sformatf("R2-vector row %0d (R3 R4 R5 R6 R7 R8 R9 R10 R11)", i), got, exp);
    end

    // R7: a configuration write beat carries the cfg and write flags
    @(negedge clk); drive(1'b0, 1'b1, 1'b1, 32'h0000_0008, 4'hB);
    @(negedge clk); drive(1'b1, 1'b0, 1'b0, 32'h7777_0000, 4'h0);
    repeat (2) @(negedge clk);
    #1;
    check("R7 cfg flags", {125'd0, xfer_valid_o, xfer_cfg_o, xfer_write_o}, {125'd0, 3'b111});
    @(negedge clk); drive(1'b1, 1'b1, 1'b0, 32'h0, 4'hF);
    repeat (2) @(negedge clk);

    // R1: reset landing mid-transaction, between edges
    drive(1'b0, 1'b1, 1'b0, 32'h8000_0200, 4'h7);
    @(negedge clk); drive(1'b0, 1'b0, 1'b0, 32'h0, 4'h0);
    @(negedge clk); #1;
    check("R1 precondition devsel", {127'd0, devsel_n_o}, 128'd0);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async reset", {124'd0, devsel_n_o, trdy_n_o, ctl_oe_o | ad_oe_o, xfer_valid_o},
          {124'd0, 4'b1100});
    @(negedge clk); drive(1'b1, 1'b1, 1'b0, 32'h0, 4'hF);
    @(negedge clk); rst_n = 1'b1;

    // R2: block accepts a fresh single-beat write after reset
    @(negedge clk); drive(1'b0, 1'b1, 1'b0, 32'h8000_0FFC, 4'h7);
    @(negedge clk); drive(1'b1, 1'b0, 1'b0, 32'hABCD_EF01, 4'h0);
    @(negedge clk); #1;
    check("R2 devsel after decode", {127'd0, devsel_n_o}, 128'd0);
    @(negedge clk); #1;
    check("R4 beat after reset", {63'd0, xfer_valid_o, xfer_addr_o, xfer_data_o},
          {63'd0, 1'b1, 32'h8000_0FFC, 32'hABCD_EF01});
    @(negedge clk); drive(1'b1, 1'b1, 1'b0, 32'h0, 4'hF);
    repeat (2) @(negedge clk);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule